// File: doc/BRIEF.md
# Serial Receive Queue with Watermark Flag

This block sits behind the bit-level shifter of a synchronous serial receiver. Each finished word arrives with a tag that marks it as primary data or as control data. Primary words go into a 16-bit by 16-entry queue. Control words go into a single holding register that has its own occupancy flag.

A 4-bit watermark sets the fill level at which the data-full flag rises. While the receive request enable is set, that flag drives both an interrupt request and a DMA request. A read made by the DMA side drops the flag as soon as the words left fall back to the watermark. A primary word that arrives while the data-full flag is set raises a sticky overrun flag and its request. A level-sensitive soft reset empties the queue.

Reads are register-style. `rd_data` always presents the oldest word, or zero when the queue is empty. A one-cycle `rd_fifo` strobe consumes that word at the next edge.

Queue occupancy is tracked by a three-state machine:
- `OCC_EMPTY`: no words held.
- `OCC_PARTIAL`: 1 to 15 words held.
- `OCC_FULL`: all 16 entries in use.

Its transitions are:
- `EMPTY->PARTIAL`: a word is stored.
- `PARTIAL->FULL`: the count reaches 16.
- `PARTIAL->EMPTY`: the last word is read.
- `FULL->PARTIAL`: a read happens without a write in the same cycle.
- `any->EMPTY`: the soft reset is high.

Top module: `serrx_wm_fifo`

## Requirements
- R1: After hardware reset `fill_count` is 0, `rd_data` is 0, and all flags and requests (`full_flag`, `ovr_flag`, `ctrl_full`, `data_irq`, `dma_req`, `ovr_irq`) are low.
- R2: Primary words (`in_valid`=1, `in_ctrl`=0) are read back in arrival order. `fill_count` tracks the number held, from 0 to 16. A read and a write in the same cycle at 16 entries leave the count at 16.
- R3: `full_flag` rises on the edge after which `fill_count` exceeds `watermark`, so it needs `watermark`+1 words.
- R4: With `irq_en`=1, `data_irq` and `dma_req` both follow `full_flag`. With `irq_en`=0 both stay low.
- R5: A read with `rd_dma`=1 clears `full_flag` when the remaining count is at or below `watermark`. A read with `rd_dma`=0 never clears it.
- R6: A `clr_full` pulse clears `full_flag` only when the count is at or below `watermark`. Otherwise the flag stays set.
- R7: A primary word that arrives while `full_flag` is set raises `ovr_flag` and `ovr_irq` on the next edge. If there is room, the word is still appended.
- R8: An overrun at 16 entries replaces the most recently written word, and the count stays 16.
- R9: A `clr_ovr` pulse clears `ovr_flag` only while `full_flag` is low.
- R10: Reading the empty queue returns 0 on `rd_data` and leaves `fill_count` at 0.
- R11: A control word (`in_ctrl`=1) loads `ctrl_data` and sets `ctrl_full`. A later control word overwrites an unread one. Control words never change `fill_count`.
- R12: `rd_ctrl` clears `ctrl_full`. A control word arriving in the same cycle wins, leaving the flag set.
- R13: While `fifo_rst` is 1, the queue is empty, `full_flag` is cleared, and primary words are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rst | input | 1 | Soft queue reset, level |
| watermark | input | 4 | Fill level the count must exceed to set `full_flag` |
| irq_en | input | 1 | Receive request enable |
| in_valid | input | 1 | Word completed by the shifter this cycle |
| in_ctrl | input | 1 | 1 = control word, 0 = primary word |
| in_data | input | 16 | Completed word |
| rd_fifo | input | 1 | Consume the oldest primary word |
| rd_dma | input | 1 | Marks a `rd_fifo` as a DMA read |
| rd_ctrl | input | 1 | Read strobe for the control register |
| clr_full | input | 1 | Write-one-to-clear for `full_flag` |
| clr_ovr | input | 1 | Write-one-to-clear for `ovr_flag` |
| rd_data | output | 16 | Oldest primary word, or 0 when empty |
| ctrl_data | output | 16 | Control holding register |
| fill_count | output | 5 | Number of primary words held |
| full_flag | output | 1 | Data-full flag |
| ovr_flag | output | 1 | Overrun flag |
| ctrl_full | output | 1 | Control register holds an unread word |
| data_irq | output | 1 | Data-full interrupt request |
| dma_req | output | 1 | Data-full DMA request |
| ovr_irq | output | 1 | Overrun request |

## Verification
The bench attacks the clearing rules. A CPU read must not drop the data-full flag, though a design that cleared it on any read would. A write-one clear at a count above the watermark must leave the flag set, which a design ignoring the count would not. An overrun at 16 entries must overwrite the newest entry rather than the oldest or a wrapped slot, which is caught by checking read order; a simultaneous read and write at 16 must not drop or duplicate a word. Empty reads, a collision between a control read and a control write, and primary words arriving during the soft reset catch designs that underflow the count, lose the new control word, or keep words they should drop.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_e;
endpackage

// File: rtl/serrx_store.sv
module serrx_store #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic         replace,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (clear) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !replace) wp <= step_up(wp);
            if (pop)              rp <= step_up(rp);
        end
    end

    // Replacement targets the slot written last, one behind the write pointer.
    always_ff @(posedge clk) begin
        if (push && !clear) mem[replace ? step_down(wp) : wp] <= din;
    end

    assign head = mem[rp];
endmodule

// File: rtl/serrx_flags.sv
module serrx_flags #(
    parameter int CW  = 5,
    parameter int WMW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fifo_rst,
    input  logic [CW-1:0]  cnt_next,
    input  logic [WMW-1:0] wm,
    input  logic           prim_in,
    input  logic           dma_pop,
    input  logic           clr_full,
    input  logic           clr_ovr,
    input  logic           ctrl_in,
    input  logic           ctrl_rd,
    output logic           full,
    output logic           ovr,
    output logic           cfull
);
    logic above;
    assign above = cnt_next > CW'(wm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full  <= 1'b0;
            ovr   <= 1'b0;
            cfull <= 1'b0;
        end else begin
            // Data-full: set on level, drop only by DMA read or W1C once below.
            if (fifo_rst)                  full <= 1'b0;
            else if (above)                full <= 1'b1;
            else if (dma_pop || clr_full)  full <= 1'b0;

            // Overrun: event sets, W1C honoured only once data-full is gone.
            if (prim_in && full)           ovr <= 1'b1;
            else if (clr_ovr && !full)     ovr <= 1'b0;

            // Control holding register occupancy: new word wins over read.
            if (ctrl_in)                   cfull <= 1'b1;
            else if (ctrl_rd)              cfull <= 1'b0;
        end
    end
endmodule

// File: rtl/serrx_wm_fifo.sv
module serrx_wm_fifo
    import serrx_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int WMW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fifo_rst,
    input  logic [WMW-1:0] watermark,
    input  logic           irq_en,
    input  logic           in_valid,
    input  logic           in_ctrl,
    input  logic [W-1:0]   in_data,
    input  logic           rd_fifo,
    input  logic           rd_dma,
    input  logic           rd_ctrl,
    input  logic           clr_full,
    input  logic           clr_ovr,
    output logic [W-1:0]   rd_data,
    output logic [W-1:0]   ctrl_data,
    output logic [CW-1:0]  fill_count,
    output logic           full_flag,
    output logic           ovr_flag,
    output logic           ctrl_full,
    output logic           data_irq,
    output logic           dma_req,
    output logic           ovr_irq
);
    occ_e          state, state_nxt;
    logic [CW-1:0] count, cnt_next;
    logic          push, pop, replace, ctrl_in;
    logic [W-1:0]  head;
    logic [W-1:0]  ctrl_q;

    always_comb begin
        push     = in_valid && !in_ctrl && !fifo_rst;
        ctrl_in  = in_valid && in_ctrl;
        pop      = rd_fifo && (state != OCC_EMPTY) && !fifo_rst;
        replace  = push && (state == OCC_FULL) && !pop;
        cnt_next = fifo_rst ? '0
                 : count + CW'(push && !replace) - CW'(pop);
    end

    // Occupancy state: next-state logic.
    always_comb begin
        state_nxt = state;
        if (fifo_rst) begin
            state_nxt = OCC_EMPTY;
        end else begin
            unique case (state)
                OCC_EMPTY: begin
                    if (cnt_next == CW'(DEPTH))  state_nxt = OCC_FULL;
                    else if (cnt_next != '0)     state_nxt = OCC_PARTIAL;
                end
                OCC_PARTIAL: begin
                    if (cnt_next == '0)          state_nxt = OCC_EMPTY;
                    else if (cnt_next == CW'(DEPTH)) state_nxt = OCC_FULL;
                end
                OCC_FULL: begin
                    if (cnt_next != CW'(DEPTH))  state_nxt = OCC_PARTIAL;
                end
                default: state_nxt = OCC_EMPTY;
            endcase
        end
    end

    // Occupancy state register with word count and control holding register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OCC_EMPTY;
            count  <= '0;
            ctrl_q <= '0;
        end else begin
            state <= state_nxt;
            count <= cnt_next;
            if (ctrl_in) ctrl_q <= in_data;
        end
    end

    serrx_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (fifo_rst),
        .push    (push),
        .replace (replace),
        .pop     (pop),
        .din     (in_data),
        .head    (head)
    );

    serrx_flags #(.CW(CW), .WMW(WMW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_rst (fifo_rst),
        .cnt_next (cnt_next),
        .wm       (watermark),
        .prim_in  (push),
        .dma_pop  (pop && rd_dma),
        .clr_full (clr_full),
        .clr_ovr  (clr_ovr),
        .ctrl_in  (ctrl_in),
        .ctrl_rd  (rd_ctrl),
        .full     (full_flag),
        .ovr      (ovr_flag),
        .cfull    (ctrl_full)
    );

    // Outputs.
    always_comb begin
        rd_data    = (state == OCC_EMPTY || fifo_rst) ? '0 : head;
        ctrl_data  = ctrl_q;
        fill_count = count;
        data_irq   = full_flag && irq_en;
        dma_req    = full_flag && irq_en;
        ovr_irq    = ovr_flag;
    end
endmodule

// File: rtl/serrx_wm_fifo_chk.sv
module serrx_wm_fifo_chk #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int CW    = 5,
    parameter int WMW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fifo_rst,
    input logic [WMW-1:0] watermark,
    input logic           irq_en,
    input logic           in_valid,
    input logic           in_ctrl,
    input logic [W-1:0]   in_data,
    input logic           rd_fifo,
    input logic [W-1:0]   rd_data,
    input logic [W-1:0]   ctrl_data,
    input logic [CW-1:0]  fill_count,
    input logic           full_flag,
    input logic           ovr_flag,
    input logic           ctrl_full,
    input logic           data_irq,
    input logic           dma_req
);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    a_r3_full_above_wm: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count > CW'(watermark) && $stable(watermark)) |-> full_flag);

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> (!data_irq && !dma_req));

    a_r7_ovr_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && in_valid && !in_ctrl && !fifo_rst) |=> ovr_flag);

    a_r8_count_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == CW'(DEPTH) && in_valid && !in_ctrl && !fifo_rst)
        |=> fill_count == CW'(DEPTH));

    a_r10_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> (rd_data == '0));

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && rd_fifo && !(in_valid && !in_ctrl)) |=> fill_count == '0);

    a_r11_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl) |=> (ctrl_full && ctrl_data == $past(in_data)));

    a_r13_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> (fill_count == '0 && !full_flag));
endmodule

bind serrx_wm_fifo serrx_wm_fifo_chk #(
    .W(W), .DEPTH(DEPTH), .CW(CW), .WMW(WMW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_rst   (fifo_rst),
    .watermark  (watermark),
    .irq_en     (irq_en),
    .in_valid   (in_valid),
    .in_ctrl    (in_ctrl),
    .in_data    (in_data),
    .rd_fifo    (rd_fifo),
    .rd_data    (rd_data),
    .ctrl_data  (ctrl_data),
    .fill_count (fill_count),
    .full_flag  (full_flag),
    .ovr_flag   (ovr_flag),
    .ctrl_full  (ctrl_full),
    .data_irq   (data_irq),
    .dma_req    (dma_req)
);

// File: tb/serrx_wm_fifo_test.sv
module serrx_wm_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_rst = 1'b0;
    logic [3:0]  watermark = 4'd3;
    logic        irq_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ctrl = 1'b0;
    logic [15:0] in_data = '0;
    logic        rd_fifo = 1'b0;
    logic        rd_dma = 1'b0;
    logic        rd_ctrl = 1'b0;
    logic        clr_full = 1'b0;
    logic        clr_ovr = 1'b0;
    logic [15:0] rd_data, ctrl_data;
    logic [4:0]  fill_count;
    logic        full_flag, ovr_flag, ctrl_full, data_irq, dma_req, ovr_irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    serrx_wm_fifo uut (
        .clk(clk), .rst_n(rst_n), .fifo_rst(fifo_rst), .watermark(watermark),
        .irq_en(irq_en), .in_valid(in_valid), .in_ctrl(in_ctrl), .in_data(in_data),
        .rd_fifo(rd_fifo), .rd_dma(rd_dma), .rd_ctrl(rd_ctrl),
        .clr_full(clr_full), .clr_ovr(clr_ovr), .rd_data(rd_data),
        .ctrl_data(ctrl_data), .fill_count(fill_count), .full_flag(full_flag),
        .ovr_flag(ovr_flag), .ctrl_full(ctrl_full), .data_irq(data_irq),
        .dma_req(dma_req), .ovr_irq(ovr_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One clock: inputs set at a falling edge take effect at the next rising edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_ctrl = 1'b0; rd_fifo = 1'b0; rd_dma = 1'b0;
        rd_ctrl = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0;
    endtask

    // Driver: predicts the queue contents as it sends a primary word.
    task automatic drive_word(input logic [15:0] d);
        in_valid = 1'b1; in_ctrl = 1'b0; in_data = d;
        if (!fifo_rst) begin
            if (exp_q.size() == 16) exp_q[$] = d;
            else exp_q.push_back(d);
        end
        tick();
    endtask

    task automatic drive_ctrl(input logic [15:0] d, input bit also_read);
        in_valid = 1'b1; in_ctrl = 1'b1; in_data = d; rd_ctrl = also_read;
        tick();
    endtask

    // Monitor: pops the oldest prediction and compares it with the read port.
    task automatic read_word(input bit dma, input string tag);
        logic [15:0] e;
        e = exp_q.pop_front();
        check(tag, rd_data, e);
        rd_fifo = 1'b1; rd_dma = dma;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", fill_count, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 flags", {full_flag, ovr_flag, ctrl_full, data_irq, dma_req, ovr_irq}, 0);

        // R3 threshold is watermark+1 words
        for (int i = 0; i < 3; i++) drive_word(16'hA000 + 16'(i));
        check("R3 below", full_flag, 0);
        check("R2 count3", fill_count, 3);
        drive_word(16'hA003);
        check("R3 above", full_flag, 1);
        check("R4 requests", {data_irq, dma_req}, 2'b11);
        irq_en = 1'b0;
        #1;
        check("R4 disabled", {data_irq, dma_req}, 2'b00);
        irq_en = 1'b1;

        // R6 W1C ignored above watermark
        clr_full = 1'b1; tick();
        check("R6 held", full_flag, 1);

        // R5 CPU read does not clear
        read_word(1'b0, "R2 order");
        check("R5 cpu read keeps", full_flag, 1);
        check("R2 count after read", fill_count, 3);
        clr_full = 1'b1; tick();
        check("R6 cleared", full_flag, 0);

        // R5 DMA read clears at watermark
        drive_word(16'hA004);
        check("R3 reset", full_flag, 1);
        read_word(1'b1, "R2 order dma");
        check("R5 dma clear", full_flag, 0);

        // R7 overrun with room
        drive_word(16'hA005);
        drive_word(16'hA006);
        check("R7 ovr", {ovr_flag, ovr_irq}, 2'b11);
        check("R7 appended", fill_count, 5);
        clr_ovr = 1'b1; tick();
        check("R9 held while full", ovr_flag, 1);
        read_word(1'b1, "R2 order");
        check("R5 above still set", full_flag, 1);
        read_word(1'b1, "R2 order");
        check("R5 dma clear 2", full_flag, 0);
        clr_ovr = 1'b1; tick();
        check("R9 cleared", ovr_flag, 0);

        // R8 fill to 16, overrun replaces newest
        for (int i = 0; i < 13; i++) drive_word(16'hB000 + 16'(i));
        check("R2 count16", fill_count, 16);
        drive_word(16'hC0DE);
        check("R8 count pinned", fill_count, 16);
        // R2 simultaneous read and write at 16
        begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check("R2 head at full", rd_data, e);
            rd_fifo = 1'b1; in_valid = 1'b1; in_data = 16'hD00D;
            exp_q.push_back(16'hD00D);
            tick();
        end
        check("R2 rw at full", fill_count, 16);
        for (int i = 0; i < 16; i++) read_word(1'b0, "R8 order after replace");
        check("R2 drained", fill_count, 0);

        // R10 empty read
        rd_fifo = 1'b1; tick();
        check("R10 count", fill_count, 0);
        check("R10 data", rd_data, 0);
        clr_full = 1'b1; tick();
        clr_ovr = 1'b1; tick();
        check("R9 tidy", {full_flag, ovr_flag}, 2'b00);

        // R11 / R12 control register
        drive_ctrl(16'hE001, 1'b0);
        check("R11 data", ctrl_data, 16'hE001);
        check("R11 full", ctrl_full, 1);
        check("R11 count untouched", fill_count, 0);
        drive_ctrl(16'hE002, 1'b0);
        check("R11 overwrite", ctrl_data, 16'hE002);
        rd_ctrl = 1'b1; tick();
        check("R12 read clears", ctrl_full, 0);
        drive_ctrl(16'hE003, 1'b1);
        check("R12 collision", {ctrl_full, ctrl_data}, {1'b1, 16'hE003});

        // R13 soft reset
        for (int i = 0; i < 5; i++) drive_word(16'hF000 + 16'(i));
        check("R3 before soft reset", full_flag, 1);
        fifo_rst = 1'b1;
        exp_q.delete();
        drive_word(16'hF0F0);
        check("R13 count", fill_count, 0);
        check("R13 full", full_flag, 0);
        drive_word(16'hF0F1);
        check("R13 dropped", fill_count, 0);
        check("R13 data", rd_data, 0);
        fifo_rst = 1'b0;
        drive_word(16'h1234);
        check("R13 after", fill_count, 1);
        read_word(1'b0, "R13 fresh word");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule